// File: doc/BRIEF.md
# Peak-Current Middle-State Hold Selector

This block belongs to one leg of a three-level flying-capacitor inverter. It sits between the capacitor-balancing selector, which proposes one of the two redundant middle states (A or B) each modulation period, and the switch-command logic. On every period strobe it takes a signed phase-current sample and forms the current slope as the difference between this sample and the previous one. It watches for the slope turning from rising to falling, which marks a positive current maximum, and from falling to rising, which marks a negative minimum.

When a turn is found, the block stops following the proposal for a programmable number of periods and keeps the middle state it last applied. The flying capacitor therefore cannot be charged and then discharged at once, or the reverse, while the phase current is at its largest. Slope values whose magnitude is within a programmable dead band count as flat. This keeps measurement noise from producing false turns. Outside the hold window the proposal passes straight through.

Two states are named: TRACK, in which the proposal is followed, and HOLD, in which the applied state is frozen. The transitions are TRACK to HOLD on a detected turn with a non-zero window, HOLD to HOLD (restart) on a further turn, HOLD to HOLD (count down) on an ordinary strobe, and HOLD to TRACK on the strobe that ends the window.

Top module: `peak_hold_sel`

## Requirements
- R1: A synchronous active-high reset sets the applied state to A (`mid_sel`=0, where 0 is A and 1 is B) and `hold_act` to 0. It clears the stored previous sample to 0 and leaves no slope direction on record, so the first strobe after reset cannot mark a turn.
- R2: The slope on each strobe is the current sample minus the previous sample. It is formed one bit wider than the input so that it never wraps: a step from 32767 to -32768 counts as falling.
- R3: A slope whose magnitude is less than or equal to `dead_band` counts as flat. A flat slope marks no turn and leaves the recorded direction unchanged.
- R4: A turn is marked when the slope is falling and the last non-flat slope was rising (positive maximum), or when it is rising and the last non-flat slope was falling (negative minimum). Both kinds start a hold when `hold_len` is non-zero.
- R5: While the hold is active, `mid_sel` keeps the last applied state whatever `prop_sel` says, and `hold_act` is 1.
- R6: The hold window covers `hold_len` strobes, counting the strobe that detects the turn. On the strobe after the last of them, `hold_act` drops and `prop_sel` is applied. A turn detected during a hold restarts the window.
- R7: With `hold_len` = 0 no hold is ever entered.
- R8: Outside a hold, each strobe loads `prop_sel` into `mid_sel`, one clock after the strobe.
- R9: In cycles without `period_stb`, `mid_sel` and `hold_act` do not change, and the sample and slope history stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | One-cycle pulse per modulation period |
| phase_cur | input | 16 | Sampled phase current, two's complement |
| prop_sel | input | 1 | Proposed middle state, 0 = A, 1 = B |
| dead_band | input | 16 | Unsigned slope magnitude treated as flat |
| hold_len | input | 4 | Hold window length in modulation periods |
| mid_sel | output | 1 | Applied middle state, 0 = A, 1 = B |
| hold_act | output | 1 | 1 while the proposal is overridden |

## Verification
The bench builds the block with its default widths (16-bit current, 4-bit window counter). It sweeps window lengths 0 through 5 against dead bands of 0, 3 and 50. These values bring within reach the disabled window, one-period holds, restarts when turns fall closer together than the window, and noise that either crosses or stays inside the dead band. Separate sequences drive the full-scale step that would wrap a same-width difference, and long strobe-free stretches with changing inputs.

// File: rtl/peak_hold_pkg.sv
package peak_hold_pkg;
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } slope_dir_t;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } hold_st_t;

    localparam logic MID_A = 1'b0;
endpackage

// File: rtl/slope_turn_det.sv
module slope_turn_det
    import peak_hold_pkg::*;
#(
    parameter int CUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [CUR_W-1:0] cur,
    input  logic [CUR_W-1:0] dead_band,
    output logic             turn_max,
    output logic             turn_min
);
    localparam int DW = CUR_W + 1;

    logic [CUR_W-1:0] prev_q;
    slope_dir_t       dir_q;
    slope_dir_t       dir_now;
    logic signed [DW-1:0] slope;
    logic [DW-1:0]    slope_mag;

    // widened difference: cannot wrap
    always_comb begin
        slope     = $signed({cur[CUR_W-1], cur}) - $signed({prev_q[CUR_W-1], prev_q});
        slope_mag = slope[DW-1] ? DW'(-slope) : DW'(slope);
        if (slope_mag > {1'b0, dead_band})
            dir_now = slope[DW-1] ? DIR_DOWN : DIR_UP;
        else
            dir_now = DIR_NONE;
    end

    assign turn_max = (dir_q == DIR_UP)   && (dir_now == DIR_DOWN);
    assign turn_min = (dir_q == DIR_DOWN) && (dir_now == DIR_UP);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            dir_q  <= DIR_NONE;
        end else if (stb) begin
            prev_q <= cur;
            if (dir_now != DIR_NONE)
                dir_q <= dir_now;
        end
    end
endmodule

// File: rtl/hold_window_fsm.sv
module hold_window_fsm
    import peak_hold_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              turn,
    input  logic              prop_sel,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              mid_sel,
    output logic              hold_act
);
    hold_st_t          st_q, st_d;
    logic [HOLD_W-1:0] rem_q, rem_d;
    logic              mid_q, mid_d;
    logic              arm;

    assign arm = turn && (hold_len != '0);

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        mid_d = mid_q;
        if (stb) begin
            unique case (st_q)
                ST_TRACK: begin
                    if (arm) begin
                        st_d  = ST_HOLD;
                        rem_d = hold_len - 1'b1;
                    end else begin
                        mid_d = prop_sel;
                    end
                end
                ST_HOLD: begin
                    if (arm) begin
                        rem_d = hold_len - 1'b1;
                    end else if (rem_q == '0) begin
                        st_d  = ST_TRACK;
                        mid_d = prop_sel;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
                default: st_d = ST_TRACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_TRACK;
            rem_q <= '0;
            mid_q <= MID_A;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
            mid_q <= mid_d;
        end
    end

    always_comb begin
        mid_sel  = mid_q;
        hold_act = (st_q == ST_HOLD);
    end
endmodule

// File: rtl/peak_hold_sel.sv
module peak_hold_sel #(
    parameter int CUR_W  = 16,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_stb,
    input  logic [CUR_W-1:0]  phase_cur,
    input  logic              prop_sel,
    input  logic [CUR_W-1:0]  dead_band,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              mid_sel,
    output logic              hold_act
);
    logic turn_max, turn_min, pk_any;

    slope_turn_det #(.CUR_W(CUR_W)) u_det (
        .clk       (clk),
        .rst       (rst),
        .stb       (period_stb),
        .cur       (phase_cur),
        .dead_band (dead_band),
        .turn_max  (turn_max),
        .turn_min  (turn_min)
    );

    assign pk_any = turn_max | turn_min;

    hold_window_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stb      (period_stb),
        .turn     (pk_any),
        .prop_sel (prop_sel),
        .hold_len (hold_len),
        .mid_sel  (mid_sel),
        .hold_act (hold_act)
    );
endmodule

// File: rtl/peak_hold_sel_chk.sv
module peak_hold_sel_chk #(
    parameter int HOLD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              period_stb,
    input logic              prop_sel,
    input logic [HOLD_W-1:0] hold_len,
    input logic              pk_any,
    input logic              mid_sel,
    input logic              hold_act
);
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!hold_act && !mid_sel)); // R1

    AST_TURN_STARTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (period_stb && pk_any && hold_len != '0) |=> hold_act); // R4

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold_act |=> (!hold_act || $stable(mid_sel))); // R5

    AST_HOLD_ENTRY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (period_stb && !hold_act && pk_any && hold_len != '0) |=> $stable(mid_sel)); // R5

    AST_HOLD_EXIT_PASSES: assert property (@(posedge clk) disable iff (rst)
        (hold_act && !pk_any && period_stb) |=> (hold_act || mid_sel == $past(prop_sel))); // R6

    AST_ZERO_LEN_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (period_stb && !hold_act && hold_len == '0) |=> !hold_act); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (period_stb && !hold_act && !pk_any) |=> (!hold_act && mid_sel == $past(prop_sel))); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> ($stable(mid_sel) && $stable(hold_act))); // R9
endmodule

bind peak_hold_sel peak_hold_sel_chk #(.HOLD_W(HOLD_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .period_stb (period_stb),
    .prop_sel   (prop_sel),
    .hold_len   (hold_len),
    .pk_any     (pk_any),
    .mid_sel    (mid_sel),
    .hold_act   (hold_act)
);

// File: tb/peak_hold_sel_tb_top.sv
`timescale 1ns/1ps
module peak_hold_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_stb = 1'b0;
    logic [15:0] phase_cur = '0;
    logic        prop_sel = 1'b0;
    logic [15:0] dead_band = '0;
    logic [3:0]  hold_len = '0;
    logic        mid_sel, hold_act;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    int m_prev, m_dir, m_rem, m_len, m_db;
    bit m_hold, m_mid;

    always #4 clk = ~clk;

    peak_hold_sel dut_i (
        .clk(clk), .rst(rst), .period_stb(period_stb), .phase_cur(phase_cur),
        .prop_sel(prop_sel), .dead_band(dead_band), .hold_len(hold_len),
        .mid_sel(mid_sel), .hold_act(hold_act)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset(input int len, input int db);
        @(negedge clk);
        rst = 1'b1; period_stb = 1'b0;
        hold_len = 4'(len); dead_band = 16'(db);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 0; m_dir = 0; m_rem = 0; m_hold = 0; m_mid = 0;
        m_len = len; m_db = db;
        chk("R1 mid after reset", int'(mid_sel), 0);
        chk("R1 hold after reset", int'(hold_act), 0);
    endtask

    // one strobe; model follows the requirements
    task automatic step(input int cur, input bit prop, input string tag);
        int d, dir;
        bit pk;
        d = cur - m_prev;                                  // R2
        dir = (d > m_db) ? 1 : ((d < -m_db) ? -1 : 0);      // R3
        pk = (m_dir == 1 && dir == -1) || (m_dir == -1 && dir == 1); // R4
        if (dir != 0) m_dir = dir;
        m_prev = cur;
        if (m_hold) begin
            if (pk && m_len > 0) m_rem = m_len - 1;        // R6 restart
            else if (m_rem == 0) begin m_hold = 0; m_mid = prop; end
            else m_rem--;
        end else begin
            if (pk && m_len > 0) begin m_hold = 1; m_rem = m_len - 1; end
            else m_mid = prop;                             // R8
        end
        @(negedge clk);
        phase_cur = 16'(cur); prop_sel = prop; period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        chk({tag, m_hold ? " R5 mid" : " R8 mid"}, int'(mid_sel), int'(m_mid));
        chk({tag, " R6 hold flag"}, int'(hold_act), int'(m_hold));
    endtask

    function automatic int wave(input int k, input int amp);
        int ph;
        ph = k % 24;
        wave = (ph < 12) ? (ph * amp / 6 - amp) : (amp - (ph - 12) * amp / 6);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R7 / R4 / R6 sweep over window length and dead band
        for (int len = 0; len <= 5; len++) begin
            for (int dbi = 0; dbi < 3; dbi++) begin
                int db;
                db = (dbi == 0) ? 0 : ((dbi == 1) ? 3 : 50);
                do_reset(len, db);
                for (int k = 0; k < 60; k++) begin
                    int c;
                    c = wave(k, 300) + ((k * 7) % 9) - 4;
                    step(c, bit'(((k * 5 + len) >> 1) & 1), len == 0 ? "R7 sweep" : "R4 sweep");
                end
            end
        end
        // R3: small noise inside the dead band never holds
        do_reset(3, 10);
        for (int k = 0; k < 20; k++)
            step(((k * 13) % 21) - 10 + 100, bit'(k & 1), "R3 noise");
        // R2: full-scale step must read as falling
        do_reset(2, 0);
        step(32767, 1'b1, "R2 up");
        step(-32768, 1'b0, "R2 wide");
        chk("R2 hold on full-scale fall", int'(hold_act), 1);
        chk("R2 kept state", int'(mid_sel), 1);
        step(-32768, 1'b0, "R2 flat");
        step(-32768, 1'b0, "R2 release");
        // R9: no strobe, inputs move, outputs stay
        do_reset(4, 0);
        step(10, 1'b1, "R9 pre");
        step(20, 1'b1, "R9 pre");
        step(5, 1'b0, "R9 turn");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            phase_cur = 16'(k * 1000 - 3000); prop_sel = ~prop_sel;
            @(negedge clk);
            chk("R9 mid idle", int'(mid_sel), 1);
            chk("R9 hold idle", int'(hold_act), 1);
        end
        for (int k = 0; k < 5; k++) step(5 - k, bit'(k & 1), "R9 post");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule